// File: doc/BRIEF.md
# Oversampling UART Receive Path with Line-Noise Flagging

This block receives asynchronous serial words. An idle line sits high. A falling edge starts a frame. The line is then sampled on an enable tick that runs at 16, 8 or 4 times the bit rate, and each bit's value is settled by the samples around its centre. In 16x mode, three samples per bit vote on the value. The same samples raise a noise flag when they disagree.

Each finished word goes into a receive FIFO together with four status flags:
- parity error
- framing error
- noise
- overrun

A host-side read strobe pops the oldest word. The popped data and its own status flags are then held on the outputs until the next pop.

The bit clock comes in as a tick enable and is not generated here. The host-bus logic sits outside the block and drives the read strobe and the configuration inputs directly.

Top module: `uartRxCore`

## Requirements
- R1: With `rxEnable` high and the receiver idle, a tick that sees the line low after a high sample starts a frame. Data arrive LSB first, 8 bits per word, and the word lands in the FIFO during the stop bit.
- R2: If the start bit's vote at its centre reads high, the frame is dropped as a glitch. Nothing is stored, and a later valid frame is still received.
- R3: In 16x mode (`rateMode`=0), each bit's value is the majority of the samples at ticks 7, 8 and 9 of that bit.
- R4: In 16x mode, `lineStatus[2]` (noise) of a word is set when the three samples of any bit of that word disagree, its start and stop bits included.
- R5: `rateMode`=1 gives 8 ticks per bit and `rateMode`=2 or 3 gives 4 ticks per bit. In these modes the bit value is the single sample at tick 4 or tick 2 respectively, and the noise flag is never set.
- R6: With `parityEn` high, a parity bit follows the data. Even parity is expected when `parityOdd`=0 and odd parity when `parityOdd`=1, and a mismatch sets `lineStatus[0]`.
- R7: A stop bit that votes low sets `lineStatus[1]` (framing error). The word is still stored.
- R8: The FIFO holds 128 words and returns them oldest first. `rxLevel` gives the count and `rxEmpty` is high when the count is zero.
- R9: When `rdEn` is high at a clock edge and the FIFO is not empty, `rdData` and `lineStatus` take the popped word and its flags at that edge. Reading an empty FIFO changes neither output.
- R10: A word that completes while the FIFO is full is discarded and the level stays at 128. The next word that is stored carries `lineStatus[3]` (overrun) set.
- R11: Lowering `rxEnable` lets the word already in progress finish and be stored. No new frame starts while it stays low.
- R12: With `rxInvert` high, the line polarity is flipped before start detection and sampling.
- R13: The receiver state advances only on cycles where `sampleTick` is high, so a slower tick stretches the bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | Oversampling enable, one pulse per sample time |
| rxIn | input | 1 | Serial receive line |
| rxEnable | input | 1 | Allows new frames to start |
| rxInvert | input | 1 | Inverts the receive line polarity |
| rateMode | input | 2 | 0: 16x, 1: 8x, 2/3: 4x ticks per bit |
| parityEn | input | 1 | A parity bit follows the data |
| parityOdd | input | 1 | Odd parity expected when high, even when low |
| rdEn | input | 1 | Pop the oldest word |
| rdData | output | DATA_W | Data of the last popped word |
| lineStatus | output | 4 | {overrun, noise, framing, parity} of the last popped word |
| rxLevel | output | $clog2(DEPTH+1) | Words held in the FIFO |
| rxEmpty | output | 1 | FIFO holds no words |

## Verification
A tick counter that drifts inside a frame moves the sampling window. The first visible effect is a wrong bit or a wrong noise flag in the next popped word, one frame later. A stuck state machine shows up within one word time as `rxLevel` failing to rise after a complete frame. Pointer or count faults show up at the first pop after the damage, as reordered data or as an `rxLevel` that disagrees with the number of frames sent minus pops. Status flags stored beside the wrong entry appear on `lineStatus` at the pop that returns that entry.

// File: rtl/uartRxPkg.sv
package uartRxPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_e;

  // Order matters: the host sees {overrun, noise, framing, parity}
  typedef struct packed {
    logic overrun;
    logic noise;
    logic frameErr;
    logic parityErr;
  } rxStatus_t;

  typedef struct packed {
    logic sampleA;       // first of the three centre samples
    logic sampleB;       // centre sample
    logic decideStart;   // third sample tick of the start bit
    logic decideData;    // third sample tick of a data bit
    logic decideParity;  // third sample tick of the parity bit
    logic decideStop;    // third sample tick of the stop bit, word complete
    logic clearWord;     // frame begins
  } rxStrobe_t;

endpackage

// File: rtl/rxFifo.sv
module rxFifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 128
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [WIDTH-1:0]             wrData,
  input  logic                         rdEn,
  output logic [WIDTH-1:0]             rdData,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int ADDR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LEVEL_W = $clog2(DEPTH + 1);
  localparam bit POW2    = (DEPTH & (DEPTH - 1)) == 0;

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr, wrNext, rdNext;
  logic [LEVEL_W-1:0] count;
  logic doWr, doRd;

  generate
    if (POW2) begin : gWrapNatural
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : gWrapCompare
      assign wrNext = (wrPtr == ADDR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == ADDR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  assign full   = (count == LEVEL_W'(DEPTH));
  assign empty  = (count == '0);
  assign level  = count;
  assign doWr   = wrEn && !full;
  assign doRd   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= wrNext;
      if (doRd) rdPtr <= rdNext;
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= LEVEL_W'(DEPTH)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !full); // R10
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (full && !rdEn) |=> (level == LEVEL_W'(DEPTH))); // R10

endmodule

// File: rtl/rxCtrl.sv
module rxCtrl
  import uartRxPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxEnable,
  input  logic [1:0] rateMode,
  input  logic       parityEn,
  input  logic       lineNow,
  input  logic       prevLine,
  input  logic       voteBit,
  output rxStrobe_t  strb
);
  localparam int TICK_W = $clog2(OVERSAMPLE) + 1;
  localparam int BIT_W  = $clog2(DATA_W) + 1;

  rxState_e           state;
  logic [TICK_W-1:0]  tickCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [1:0]         effMode;
  logic [TICK_W-1:0]  ticksPerBit, midTick;
  logic atA, atB, atC, lastTick, startEdge, inFrame;

  always_comb begin
    effMode     = (rateMode == 2'd3) ? 2'd2 : rateMode;
    ticksPerBit = TICK_W'(OVERSAMPLE) >> effMode;
    midTick     = ticksPerBit >> 1;
    atA         = (tickCnt == midTick - 1'b1);
    atB         = (tickCnt == midTick);
    atC         = (tickCnt == midTick + 1'b1);
    lastTick    = (tickCnt == ticksPerBit - 1'b1);
    inFrame     = (state != ST_IDLE);
    startEdge   = sampleTick && (state == ST_IDLE) && rxEnable && prevLine && !lineNow;
  end

  always_comb begin
    strb              = '0;
    strb.sampleA      = sampleTick && inFrame && atA;
    strb.sampleB      = sampleTick && inFrame && atB;
    strb.decideStart  = sampleTick && (state == ST_START)  && atC;
    strb.decideData   = sampleTick && (state == ST_DATA)   && atC;
    strb.decideParity = sampleTick && (state == ST_PARITY) && atC;
    strb.decideStop   = sampleTick && (state == ST_STOP)   && atC;
    strb.clearWord    = startEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (startEdge) begin
      state   <= ST_START;
      tickCnt <= TICK_W'(1);
      bitCnt  <= '0;
    end else if (sampleTick) begin
      case (state)
        ST_START: begin
          if (atC && voteBit) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end else if (lastTick) begin
            state   <= ST_DATA;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (lastTick) begin
            tickCnt <= '0;
            if (bitCnt == BIT_W'(DATA_W - 1)) begin
              state <= parityEn ? ST_PARITY : ST_STOP;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          if (lastTick) begin
            state   <= ST_STOP;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (atC) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: begin
          state   <= ST_IDLE;
          tickCnt <= '0;
        end
      endcase
    end
  end

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !rxEnable) |=> (state == ST_IDLE)); // R11
  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> ($stable(state) && $stable(tickCnt))); // R13
  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < ticksPerBit); // R5
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && $past(state) != ST_START) |-> ($past(state) == ST_IDLE)); // R1

endmodule

// File: rtl/rxDatapath.sv
module rxDatapath
  import uartRxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rxIn,
  input  logic                        rxInvert,
  input  logic                        sampleTick,
  input  logic [1:0]                  rateMode,
  input  logic                        parityOdd,
  input  rxStrobe_t                   strb,
  input  logic                        rdEn,
  output logic                        lineNow,
  output logic                        prevLine,
  output logic                        voteBit,
  output logic [DATA_W-1:0]           rdData,
  output rxStatus_t                   lineStatus,
  output logic [$clog2(DEPTH+1)-1:0]  rxLevel,
  output logic                        rxEmpty
);
  localparam int STAT_W  = $bits(rxStatus_t);
  localparam int ENTRY_W = DATA_W + STAT_W;

  logic              syncA;
  logic              sA, sB;
  logic              fullRate, bitNoisy;
  logic [DATA_W-1:0] shiftReg;
  logic              noiseAcc, parityErr, overrunPend;
  logic              fifoFull, pushOk, popOk;
  rxStatus_t         pushStatus, popStatus;
  logic [ENTRY_W-1:0] fifoIn, fifoOut;

  // Two-stage synchronizer; polarity fixed before anything looks at the line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      lineNow  <= 1'b1;
      prevLine <= 1'b1;
    end else begin
      syncA   <= rxIn ^ rxInvert;
      lineNow <= syncA;
      if (sampleTick) prevLine <= lineNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sA <= 1'b1;
      sB <= 1'b1;
    end else begin
      if (strb.sampleA) sA <= lineNow;
      if (strb.sampleB) sB <= lineNow;
    end
  end

  always_comb begin
    fullRate = (rateMode == 2'd0);
    voteBit  = fullRate ? ((sA & sB) | (sA & lineNow) | (sB & lineNow)) : sB;
    bitNoisy = fullRate && !((sA == sB) && (sB == lineNow));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      noiseAcc  <= 1'b0;
      parityErr <= 1'b0;
    end else if (strb.clearWord) begin
      shiftReg  <= '0;
      noiseAcc  <= 1'b0;
      parityErr <= 1'b0;
    end else begin
      if (strb.decideData) shiftReg <= {voteBit, shiftReg[DATA_W-1:1]};
      if ((strb.decideStart || strb.decideData || strb.decideParity) && bitNoisy)
        noiseAcc <= 1'b1;
      if (strb.decideParity) parityErr <= (voteBit != ((^shiftReg) ^ parityOdd));
    end
  end

  always_comb begin
    pushStatus.overrun   = overrunPend;
    pushStatus.noise     = noiseAcc || bitNoisy;
    pushStatus.frameErr  = !voteBit;
    pushStatus.parityErr = parityErr;
    pushOk = strb.decideStop && !fifoFull;
    popOk  = rdEn && !rxEmpty;
    fifoIn = {shiftReg, pushStatus};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overrunPend <= 1'b0;
    else if (strb.decideStop) overrunPend <= fifoFull;
  end

  rxFifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) uFifo (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (pushOk),
    .wrData(fifoIn),
    .rdEn  (popOk),
    .rdData(fifoOut),
    .full  (fifoFull),
    .empty (rxEmpty),
    .level (rxLevel)
  );

  assign popStatus = rxStatus_t'(fifoOut[STAT_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData     <= '0;
      lineStatus <= '0;
    end else if (popOk) begin
      rdData     <= fifoOut[ENTRY_W-1:STAT_W];
      lineStatus <= popStatus;
    end
  end

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rxEmpty) |=> ($stable(rdData) && $stable(lineStatus))); // R9
  AST_NOISE_FULL_RATE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decideStop && !fullRate) |-> !pushStatus.noise); // R5
  AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decideStop && fifoFull && !rdEn) |=> $stable(rxLevel)); // R10

endmodule

// File: rtl/uartRxCore.sv
module uartRxCore
  import uartRxPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 128,
  parameter int OVERSAMPLE = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sampleTick,
  input  logic                        rxIn,
  input  logic                        rxEnable,
  input  logic                        rxInvert,
  input  logic [1:0]                  rateMode,
  input  logic                        parityEn,
  input  logic                        parityOdd,
  input  logic                        rdEn,
  output logic [DATA_W-1:0]           rdData,
  output logic [3:0]                  lineStatus,
  output logic [$clog2(DEPTH+1)-1:0]  rxLevel,
  output logic                        rxEmpty
);
  rxStrobe_t strb;
  rxStatus_t statusWord;
  logic lineNow, prevLine, voteBit;

  rxCtrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .rxEnable  (rxEnable),
    .rateMode  (rateMode),
    .parityEn  (parityEn),
    .lineNow   (lineNow),
    .prevLine  (prevLine),
    .voteBit   (voteBit),
    .strb      (strb)
  );

  rxDatapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .rxIn      (rxIn),
    .rxInvert  (rxInvert),
    .sampleTick(sampleTick),
    .rateMode  (rateMode),
    .parityOdd (parityOdd),
    .strb      (strb),
    .rdEn      (rdEn),
    .lineNow   (lineNow),
    .prevLine  (prevLine),
    .voteBit   (voteBit),
    .rdData    (rdData),
    .lineStatus(statusWord),
    .rxLevel   (rxLevel),
    .rxEmpty   (rxEmpty)
  );

  assign lineStatus = statusWord;

endmodule

// File: tb/sim_uartRxCore.sv
module sim_uartRxCore;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b1;
  logic rxIn = 1'b1;
  logic rxEnable = 1'b1;
  logic rxInvert = 1'b0;
  logic [1:0] rateMode = 2'd0;
  logic parityEn = 1'b0;
  logic parityOdd = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] rdData;
  logic [3:0] lineStatus;
  logic [7:0] rxLevel;
  logic rxEmpty;

  int checks = 0;
  int fails = 0;
  int tickDiv = 1;
  int tickPh = 0;
  logic tbInv = 1'b0;
  bit finished = 1'b0;

  uartRxCore u0 (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxIn(rxIn),
    .rxEnable(rxEnable), .rxInvert(rxInvert), .rateMode(rateMode),
    .parityEn(parityEn), .parityOdd(parityOdd), .rdEn(rdEn),
    .rdData(rdData), .lineStatus(lineStatus), .rxLevel(rxLevel), .rxEmpty(rxEmpty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tickPh = tickPh + 1;
    sampleTick = ((tickPh % tickDiv) == 0);
  end

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxIn = 1'b1 ^ tbInv;
    end
  endtask

  // bit index 0 = start, 1..8 = data LSB first, then optional parity, then stop
  task automatic sendFrame(input logic [7:0] d, input int bitLen, input bit withPar,
                           input logic parBit, input logic stopVal,
                           input int gBit, input int gAt, input int dropBit);
    logic [10:0] bits;
    int n;
    logic v;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    n = withPar ? 11 : 10;
    if (withPar) bits[9] = parBit;
    bits[n-1] = stopVal;
    for (int b = 0; b < n; b++) begin
      for (int c = 0; c < bitLen; c++) begin
        @(negedge clk);
        if (b == dropBit && c == 0) rxEnable = 1'b0;
        v = bits[b];
        if (b == gBit && c == gAt) v = ~v;
        rxIn = v ^ tbInv;
      end
    end
    idle(8);
  endtask

  task automatic sendPlain(input logic [7:0] d);
    sendFrame(d, 16, 1'b0, 1'b0, 1'b1, -1, 0, -1);
  endtask

  task automatic popCheck(input string req, input logic [7:0] expData, input logic [3:0] expStat);
    @(negedge clk);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    chk({req, " data"}, rdData, expData);
    chk({req, " status"}, lineStatus, expStat);
  endtask

  task automatic testReset();
    chk("R8 reset empty", rxEmpty, 1);
    chk("R8 reset level", rxLevel, 0);
    chk("R9 reset data", rdData, 0);
    chk("R9 reset status", lineStatus, 0);
  endtask

  task automatic testBasic();
    sendPlain(8'h55);
    sendPlain(8'hC3);
    chk("R8 level two", rxLevel, 2);
    popCheck("R1 first word", 8'h55, 4'h0);
    popCheck("R8 oldest order", 8'hC3, 4'h0);
    chk("R8 empty after pops", rxEmpty, 1);
    popCheck("R9 empty read unchanged", 8'hC3, 4'h0);
  endtask

  task automatic testParity();
    parityEn = 1'b1;
    parityOdd = 1'b0;
    sendFrame(8'hA7, 16, 1'b1, ^8'hA7, 1'b1, -1, 0, -1);
    sendFrame(8'hA7, 16, 1'b1, ~(^8'hA7), 1'b1, -1, 0, -1);
    parityOdd = 1'b1;
    sendFrame(8'h31, 16, 1'b1, ~(^8'h31), 1'b1, -1, 0, -1);
    sendFrame(8'h31, 16, 1'b1, ^8'h31, 1'b1, -1, 0, -1);
    popCheck("R6 even ok", 8'hA7, 4'h0);
    popCheck("R6 even bad", 8'hA7, 4'h1);
    popCheck("R6 odd ok", 8'h31, 4'h0);
    popCheck("R6 odd bad", 8'h31, 4'h1);
    parityEn = 1'b0;
    parityOdd = 1'b0;
  endtask

  task automatic testFraming();
    sendFrame(8'h81, 16, 1'b0, 1'b0, 1'b0, -1, 0, -1);
    idle(20);
    chk("R7 one word, no false start", rxLevel, 1);
    popCheck("R7 framing", 8'h81, 4'h2);
  endtask

  task automatic testNoise();
    // single-cycle flip at centre tick 8 of data bit 1
    sendFrame(8'h0F, 16, 1'b0, 1'b0, 1'b1, 2, 8, -1);
    popCheck("R4 noisy centre, R3 majority", 8'h0F, 4'h4);
    sendFrame(8'hF0, 16, 1'b0, 1'b0, 1'b1, 4, 2, -1);
    popCheck("R3 edge glitch outside window", 8'hF0, 4'h0);
  endtask

  task automatic testGlitchStart();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rxIn = 1'b0 ^ tbInv;
    end
    idle(40);
    chk("R2 glitch not stored", rxLevel, 0);
    sendPlain(8'h6E);
    popCheck("R2 next frame ok", 8'h6E, 4'h0);
  endtask

  task automatic testInvert();
    @(negedge clk);
    tbInv = 1'b1;
    rxInvert = 1'b1;
    rxIn = 1'b0;
    idle(10);
    sendPlain(8'h3C);
    popCheck("R12 inverted", 8'h3C, 4'h0);
    @(negedge clk);
    tbInv = 1'b0;
    rxInvert = 1'b0;
    rxIn = 1'b1;
    idle(10);
  endtask

  task automatic testRates();
    rateMode = 2'd1;
    sendFrame(8'h0F, 8, 1'b0, 1'b0, 1'b1, 2, 4, -1);
    popCheck("R5 8x centre sample, no noise", 8'h0D, 4'h0);
    rateMode = 2'd2;
    sendFrame(8'h96, 4, 1'b0, 1'b0, 1'b1, -1, 0, -1);
    popCheck("R5 4x word", 8'h96, 4'h0);
    rateMode = 2'd3;
    sendFrame(8'h5A, 4, 1'b0, 1'b0, 1'b1, -1, 0, -1);
    popCheck("R5 mode3 as 4x", 8'h5A, 4'h0);
    rateMode = 2'd0;
  endtask

  task automatic testSlowTick();
    tickDiv = 2;
    idle(4);
    sendFrame(8'hE1, 32, 1'b0, 1'b0, 1'b1, -1, 0, -1);
    idle(10);
    tickDiv = 1;
    popCheck("R13 slow tick", 8'hE1, 4'h0);
  endtask

  task automatic testEnable();
    sendFrame(8'h4B, 16, 1'b0, 1'b0, 1'b1, -1, 0, 4);
    chk("R11 word in flight kept", rxLevel, 1);
    sendPlain(8'h77);
    chk("R11 disabled frame ignored", rxLevel, 1);
    popCheck("R11 kept word", 8'h4B, 4'h0);
    @(negedge clk);
    rxEnable = 1'b1;
    idle(4);
  endtask

  task automatic testOverrun();
    for (int i = 0; i < 128; i++) sendPlain(8'(i));
    chk("R8 full level", rxLevel, 128);
    sendPlain(8'hEE);
    chk("R10 level stays full", rxLevel, 128);
    popCheck("R10 first after fill", 8'h00, 4'h0);
    sendPlain(8'hA5);
    for (int i = 1; i < 128; i++) popCheck("R8 fill order", 8'(i), 4'h0);
    popCheck("R10 overrun flagged", 8'hA5, 4'h8);
    chk("R8 drained", rxEmpty, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(4);
    testReset();
    testBasic();
    testParity();
    testFraming();
    testNoise();
    testGlitchStart();
    testInvert();
    testRates();
    testSlowTick();
    testEnable();
    testOverrun();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule